// File: doc/BRIEF.md
# Selectable-Source Clock Divider Chain

This block derives a processor clock and a slower peripheral clock from one of two candidate source clocks. A mode input picks either the local oscillator signal or an externally supplied frequency input. The two are combined with plain AND-OR gating. Each rising edge of the chosen source advances a divide-by-3 counter, which forms the processor clock. Every rising edge of that processor clock toggles a divide-by-2 stage, which forms the peripheral clock. A 15 MHz source therefore yields a 5 MHz processor clock and a 2.5 MHz peripheral clock.

The whole block runs on one fast system clock. Both source inputs are treated as data levels. They are resynchronised through a configurable number of flip-flop stages, and their rising edges are detected as one-cycle ticks. Two further signals are produced. The first is a buffered copy of the oscillator input, so that a second identical generator can take it as its external source. The second is a phase strobe that marks each processor-clock rising edge, for use by ready-timing logic. A synchronous clear input forces both counters back to a known phase.

Top module: `clkdiv_chain`

## Requirements
- R1: With `srcSel` = 0, only rising edges of `oscIn` advance the divider chain. Activity on `extIn` has no effect.
- R2: With `srcSel` = 1, only rising edges of `extIn` advance the divider chain. Activity on `oscIn` has no effect.
- R3: `oscOut` equals `oscIn` at all times, whatever the value of `srcSel`.
- R4: `cpuClk` rises on every third source rising edge. It stays high for one source period and low for two.
- R5: `periphClk` toggles on each rising edge of `cpuClk` and holds its value otherwise, so its frequency is half that of `cpuClk`.
- R6: `phaseStrobe` is high for exactly one system-clock cycle. That cycle is the one in which `cpuClk` goes high, and it happens once per `cpuClk` period.
- R7: `clear` = 1, sampled on a system-clock edge, drives `cpuClk`, `periphClk` and `phaseStrobe` to 0 on that edge. The next `cpuClk` rise comes on the third source rising edge seen after `clear` returns to 0.
- R8: `rstN` = 0 asynchronously drives `cpuClk`, `periphClk` and `phaseStrobe` to 0. It also empties the input synchronisers.
- R9: With the default two synchroniser stages, a source rising edge at the inputs shows up on `cpuClk` three system-clock edges later.
- R10: A change of `srcSel` is gated like a source change. If the newly selected input is high while the old one was low, that counts as one source rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | Fast system clock that samples both sources |
| rstN | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous counter clear, active high |
| srcSel | input | 1 | Source choice: 0 oscillator, 1 external input |
| oscIn | input | 1 | Local oscillator level |
| extIn | input | 1 | External frequency input level |
| oscOut | output | 1 | Buffered copy of `oscIn` |
| cpuClk | output | 1 | Source divided by 3, one-third duty cycle |
| periphClk | output | 1 | `cpuClk` divided by 2 |
| phaseStrobe | output | 1 | One-cycle pulse at each `cpuClk` rise |

## Verification
The hardest case to reach from the ports is a source switch that lands when the two inputs disagree. In that case the gated level jumps, a spurious edge is counted, and the divider phase shifts. The stimulus therefore runs both sources free at unrelated half-periods and flips `srcSel` every 37 cycles, so that switches fall on many relative phases. Separate phases hold one source still by hand to measure the edge-to-output latency, and pulse `clear` and `rstN` mid-stream.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  typedef struct packed {
    logic tick;
    logic clear;
  } divStrobe_t;
endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       sysClk,
  input  logic       rstN,
  input  logic       clear,
  input  logic       srcSel,
  input  logic       oscIn,
  input  logic       extIn,
  output logic       oscOut,
  output divStrobe_t strobes
);
  logic                   selLvl;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;

  // AND-OR gating of the two candidate sources
  assign selLvl = (oscIn & ~srcSel) | (extIn & srcSel);
  assign oscOut = oscIn;

  generate
    if (SYNC_STAGES == 1) begin : gSync1
      always_ff @(posedge sysClk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= selLvl;
      end
    end else begin : gSyncN
      always_ff @(posedge sysClk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], selLvl};
      end
    end
  endgenerate

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncQ[SYNC_STAGES-1];
  end

  assign strobes.tick  = syncQ[SYNC_STAGES-1] & ~prevQ;
  assign strobes.clear = clear;
endmodule

// File: rtl/clkdiv_dp.sv
module clkdiv_dp
  import clkdiv_pkg::*;
#(
  parameter int CLK_DIV = 3
) (
  input  logic       sysClk,
  input  logic       rstN,
  input  divStrobe_t strobes,
  output logic       cpuClk,
  output logic       periphClk,
  output logic       phaseStrobe
);
  localparam int CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_DIV - 1);

  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] phaseNext;
  logic             wrap;

  always_comb begin
    phaseNext = (phaseCnt == LAST) ? '0 : phaseCnt + 1'b1;
    wrap      = strobes.tick && (phaseNext == '0);
  end

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt    <= '0;
      cpuClk      <= 1'b0;
      periphClk   <= 1'b0;
      phaseStrobe <= 1'b0;
    end else if (strobes.clear) begin
      phaseCnt    <= '0;
      cpuClk      <= 1'b0;
      periphClk   <= 1'b0;
      phaseStrobe <= 1'b0;
    end else begin
      phaseStrobe <= wrap;
      if (strobes.tick) begin
        phaseCnt <= phaseNext;
        cpuClk   <= (phaseNext == '0);
      end
      if (wrap) periphClk <= ~periphClk;
    end
  end
endmodule

// File: rtl/clkdiv_chain.sv
module clkdiv_chain
  import clkdiv_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CLK_DIV     = 3
) (
  input  logic sysClk,
  input  logic rstN,
  input  logic clear,
  input  logic srcSel,
  input  logic oscIn,
  input  logic extIn,
  output logic oscOut,
  output logic cpuClk,
  output logic periphClk,
  output logic phaseStrobe
);
  divStrobe_t strobes;

  clkdiv_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .sysClk (sysClk),
    .rstN   (rstN),
    .clear  (clear),
    .srcSel (srcSel),
    .oscIn  (oscIn),
    .extIn  (extIn),
    .oscOut (oscOut),
    .strobes(strobes)
  );

  clkdiv_dp #(.CLK_DIV(CLK_DIV)) uDp (
    .sysClk     (sysClk),
    .rstN       (rstN),
    .strobes    (strobes),
    .cpuClk     (cpuClk),
    .periphClk  (periphClk),
    .phaseStrobe(phaseStrobe)
  );
endmodule

// File: rtl/clkdiv_chain_chk.sv
module clkdiv_chain_chk (
  input logic sysClk,
  input logic rstN,
  input logic clear,
  input logic srcSel,
  input logic oscIn,
  input logic extIn,
  input logic oscOut,
  input logic cpuClk,
  input logic periphClk,
  input logic phaseStrobe
);
  AST_OSC_PASS: assert property (@(posedge sysClk) disable iff (!rstN)
    oscOut == oscIn); // R3

  AST_STROBE_SINGLE: assert property (@(posedge sysClk) disable iff (!rstN)
    phaseStrobe |=> !phaseStrobe); // R6

  AST_STROBE_AT_RISE: assert property (@(posedge sysClk) disable iff (!rstN)
    phaseStrobe |-> (cpuClk && !$past(cpuClk))); // R4

  AST_PCLK_TOGGLE: assert property (@(posedge sysClk) disable iff (!rstN)
    phaseStrobe |-> (periphClk != $past(periphClk))); // R5

  AST_PCLK_HOLD: assert property (@(posedge sysClk) disable iff (!rstN)
    (!phaseStrobe && !$past(clear)) |-> $stable(periphClk)); // R5

  AST_CLEAR_IDLE: assert property (@(posedge sysClk) disable iff (!rstN)
    clear |=> (!cpuClk && !periphClk && !phaseStrobe)); // R7
endmodule

bind clkdiv_chain clkdiv_chain_chk uChk (.*);

// File: tb/sim_clkdiv_chain.sv
module sim_clkdiv_chain;
  logic sysClk = 1'b0;
  logic rstN, clear, srcSel;
  logic oscIn, extIn, oscOut, cpuClk, periphClk, phaseStrobe;

  logic autoOsc = 1'b1;
  logic oscMan = 1'b0;
  logic oscAuto = 1'b0;
  int   oscHalf = 2, extHalf = 3, oscCnt = 0, extCnt = 0;
  logic holdCmp = 1'b0;
  string curReq = "R8";

  int vectors = 0, misses = 0;

  // behavioural reference state
  logic mPipe0, mPipe1, mPrev, mClk, mPclk, mStb;
  int   mTicks;

  always #10 sysClk = ~sysClk;

  assign oscIn = autoOsc ? oscAuto : oscMan;

  clkdiv_chain u0 (
    .sysClk(sysClk), .rstN(rstN), .clear(clear), .srcSel(srcSel),
    .oscIn(oscIn), .extIn(extIn), .oscOut(oscOut), .cpuClk(cpuClk),
    .periphClk(periphClk), .phaseStrobe(phaseStrobe)
  );

  // free-running sources
  always @(negedge sysClk) begin
    oscCnt = oscCnt + 1;
    if (oscCnt >= oscHalf) begin oscCnt = 0; oscAuto = ~oscAuto; end
    extCnt = extCnt + 1;
    if (extCnt >= extHalf) begin extCnt = 0; extIn = ~extIn; end
  end

  // reference model: two resync stages, edge detect, count ticks mod 3
  always @(posedge sysClk) begin
    if (!rstN) begin
      mPipe0 = 0; mPipe1 = 0; mPrev = 0;
      mClk = 0; mPclk = 0; mStb = 0; mTicks = 0;
    end else begin
      logic tick;
      tick = mPipe1 && !mPrev;
      mPrev = mPipe1;
      mPipe1 = mPipe0;
      mPipe0 = srcSel ? extIn : oscIn;
      if (clear) begin
        mClk = 0; mPclk = 0; mStb = 0; mTicks = 0;
      end else begin
        mStb = 0;
        if (tick) begin
          mTicks = mTicks + 1;
          if (mTicks % 3 == 0) begin mClk = 1; mStb = 1; mPclk = ~mPclk; end
          else mClk = 0;
        end
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp, input string what);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge sysClk) begin
    #2;
    if (!holdCmp) begin
      check(curReq == "R8" ? "R8" : "R4", cpuClk, mClk, "cpuClk");
      check(curReq == "R8" ? "R8" : "R5", periphClk, mPclk, "periphClk");
      check(curReq == "R8" ? "R8" : "R6", phaseStrobe, mStb, "phaseStrobe");
      check("R3", oscOut, oscIn, "oscOut");
      if (curReq != "R8") check(curReq, cpuClk, mClk, "cpuClk in phase");
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge sysClk);
  endtask

  initial begin
    rstN = 0; clear = 0; srcSel = 0; extIn = 0;
    idle(4);
    curReq = "R8";
    idle(2);
    rstN = 1;

    curReq = "R1"; srcSel = 0; idle(240);
    curReq = "R2"; srcSel = 1; idle(240);

    curReq = "R10";
    for (int k = 0; k < 12; k++) begin
      srcSel = ~srcSel; idle(37);
    end

    curReq = "R7";
    for (int k = 0; k < 4; k++) begin
      idle(13 + k * 7);
      clear = 1; idle(1); clear = 0;
      idle(30);
    end

    // R4: ratio of CPU clock rises to source rises
    begin
      int srcRise = 0, clkRise = 0;
      logic lastSrc, lastClk;
      curReq = "R4"; srcSel = 1;
      clear = 1; idle(1); clear = 0;
      lastSrc = extIn; lastClk = cpuClk;
      for (int i = 0; i < 900; i++) begin
        @(negedge sysClk); #3;
        if (extIn && !lastSrc) srcRise++;
        if (cpuClk && !lastClk) clkRise++;
        lastSrc = extIn; lastClk = cpuClk;
      end
      vectors++;
      if ((srcRise / 3 - clkRise) > 1 || (srcRise / 3 - clkRise) < -1) begin
        misses++;
        $display("FAIL R4 clkRise actual=%0d expected=%0d", clkRise, srcRise / 3);
      end
    end

    // R9: manual oscillator edges, latency of three edges
    curReq = "R9"; srcSel = 0; oscMan = 0; autoOsc = 0;
    idle(6);
    clear = 1; idle(1); clear = 0;
    for (int p = 0; p < 2; p++) begin
      oscMan = 1; idle(4); oscMan = 0; idle(4);
    end
    oscMan = 1;
    @(posedge sysClk); @(posedge sysClk); #3;
    check("R9", cpuClk, 1'b0, "cpuClk after two edges");
    @(posedge sysClk); #3;
    check("R9", cpuClk, 1'b1, "cpuClk after three edges");
    check("R6", phaseStrobe, 1'b1, "strobe at rise");
    idle(6); oscMan = 0; idle(6);
    autoOsc = 1;
    idle(60);

    // R8: asynchronous reset mid-stream
    curReq = "R8";
    @(negedge sysClk);
    holdCmp = 1;
    rstN = 0; #3;
    check("R8", cpuClk, 1'b0, "cpuClk async");
    check("R8", periphClk, 1'b0, "periphClk async");
    check("R8", phaseStrobe, 1'b0, "strobe async");
    idle(2);
    holdCmp = 0;
    idle(2);
    rstN = 1;
    curReq = "R1"; idle(100);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(20 * 200000);
    misses++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule